// File: doc/BRIEF.md
# FIFO Printer Strobe Sequencer

The block takes bytes from a host write port, holds them in an 83-entry first-in first-out store, and plays them out one at a time on an 8-bit printer data bus. For each byte it places the data on the bus and waits a programmed number of clocks. It then pulls an active-low strobe low for a programmed number of clocks and releases it. It then holds off until the printer acknowledges before taking the next byte. A 3-bit timing select picks the delay and width pair. A select input chooses whether the acknowledge input or the busy input paces the transfer.

An enable input switches the store on. While it is low, the store is emptied, the sequencer sits idle with the strobe released, host writes are thrown away and a disabled flag is raised. The fill level is visible as a 7-bit byte count, together with full and empty flags. All inputs are taken to be synchronous to the block clock.

Top module: `prn_strobe_fifo`

## Requirements
- R1: After a synchronous reset the strobe output is high, the byte count is 0, the empty flag is 1, the full flag is 0, the disabled flag is 1 and the data bus is 0.
- R2: The disabled flag equals the inverse of the enable input sampled at the previous clock edge, and a host write made while enable is low changes nothing.
- R3: Each accepted host write raises the byte count by one, each byte taken by the sequencer lowers it by one, and the empty flag is 1 exactly when the count is 0.
- R4: The full flag is 1 exactly when the count is 83; a host write made while full is dropped, the count does not rise, and the dropped byte is never sent.
- R5: A host write and a sequencer pop on the same edge, with the store neither empty nor full, leave the count unchanged.
- R6: Bytes reach the data bus in the order they were written; the bus takes a new byte on the edge that pops it and holds it until the next pop.
- R7: With the timing select sampled at the pop edge, the strobe falls D edges after the pop and stays low for W clocks. The select codes map to D/W as follows: 000→6/4, 001→10/8, 010→10/8, 011→18/16, 100→3/2, 101→5/4, 110→5/4, 111→9/8.
- R8: With the handshake select at 0, the sequencer waits after the strobe rises for a high-to-low change of the acknowledge input between two consecutive clock samples; a change that happened before the strobe rose does not count.
- R9: With the handshake select at 1, the wait after the strobe rises ends on the first clock edge at which the busy input is sampled low.
- R10: The edge that ends the handshake wait returns the sequencer to idle, and if a byte is stored the next edge pops it.
- R11: Driving enable low empties the store at the next edge. The count becomes 0, the strobe is forced high, and any byte still queued is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one byte per high cycle |
| host_data | input | 8 | Host write data |
| fifo_on | input | 1 | Enable; low empties the store and idles the sequencer |
| tsel | input | 3 | Strobe timing select |
| hs_busy_sel | input | 1 | Handshake source: 0 acknowledge, 1 busy |
| prn_busy | input | 1 | Printer busy, active high |
| prn_ack_n | input | 1 | Printer acknowledge, active low |
| prn_data | output | 8 | Printer data bus |
| prn_strobe_n | output | 1 | Printer strobe, active low |
| fifo_full | output | 1 | Store holds 83 bytes |
| fifo_empty | output | 1 | Store holds no bytes |
| fifo_cnt | output | 7 | Number of bytes stored |
| fifo_off | output | 1 | Disabled flag |

## Verification
If the pointers or the count go wrong inside the store, the byte count and the flags diverge from the model on the very next edge. A wrong pointer that leaves the count correct shows up later, as a wrong or repeated byte on the data bus at the following pop. A sequencer counter that is off by one moves the strobe's falling or rising edge by a clock, and the per-clock comparison catches this within the delay or width window of that byte. A handshake decoded wrongly either stalls the bus, which shows as the strobe never falling again, or pops early, which shows as the data bus changing before the model expects.

// File: rtl/psq_pkg.sv
package psq_pkg;

  localparam int TMW = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_PULSE,
    ST_WAIT
  } seq_st_t;

  typedef struct packed {
    logic [TMW-1:0] dly;
    logic [TMW-1:0] wid;
  } strobe_tm_t;

  // Width doubles across the low two select bits (x1, x2, x2, x4) from a base
  // of 4 or 2; the delay is the width plus 2 or plus 1.
  function automatic strobe_tm_t tm_lookup(input logic [2:0] sel);
    strobe_tm_t r;
    logic [TMW-1:0] base;
    base = sel[2] ? TMW'(2) : TMW'(4);
    case (sel[1:0])
      2'b00:   r.wid = base;
      2'b11:   r.wid = base << 2;
      default: r.wid = base << 1;
    endcase
    r.dly = r.wid + (sel[2] ? TMW'(1) : TMW'(2));
    return r;
  endfunction

endpackage

// File: rtl/psq_fifo.sv
module psq_fifo #(
  parameter int DEPTH = 83,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = wr & ~full & ~clr;
  assign rd_ok = rd & ~empty & ~clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_ok) begin
      rdata <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= bump(wp);
      if (rd_ok) rp <= bump(rp);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/psq_seq.sv
module psq_seq
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       empty,
  input  logic [2:0] tsel,
  input  logic       hs_busy_sel,
  input  logic       busy,
  input  logic       ack_n,
  output logic       pop,
  output logic       strobe_n
);
  seq_st_t        st;
  logic [TMW-1:0] cnt, wid_q;
  logic           ack_q;
  logic           hs_done;
  strobe_tm_t     tm;

  always_comb tm = tm_lookup(tsel);

  assign hs_done = hs_busy_sel ? ~busy : (ack_q & ~ack_n);
  assign pop     = en & (st == ST_IDLE) & ~empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      wid_q    <= '0;
      strobe_n <= 1'b1;
      ack_q    <= 1'b1;
    end else begin
      ack_q <= ack_n;
      if (!en) begin
        st       <= ST_IDLE;
        cnt      <= '0;
        strobe_n <= 1'b1;
      end else begin
        case (st)
          ST_IDLE: if (pop) begin
            cnt   <= tm.dly - TMW'(1);
            wid_q <= tm.wid;
            st    <= ST_DELAY;
          end
          ST_DELAY: if (cnt == '0) begin
            strobe_n <= 1'b0;
            cnt      <= wid_q - TMW'(1);
            st       <= ST_PULSE;
          end else begin
            cnt <= cnt - 1'b1;
          end
          ST_PULSE: if (cnt == '0) begin
            strobe_n <= 1'b1;
            st       <= ST_WAIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
          ST_WAIT: if (hs_done) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/prn_strobe_fifo.sv
module prn_strobe_fifo #(
  parameter int DEPTH = 83,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [DW-1:0] host_data,
  input  logic          fifo_on,
  input  logic [2:0]    tsel,
  input  logic          hs_busy_sel,
  input  logic          prn_busy,
  input  logic          prn_ack_n,
  output logic [DW-1:0] prn_data,
  output logic          prn_strobe_n,
  output logic          fifo_full,
  output logic          fifo_empty,
  output logic [CW-1:0] fifo_cnt,
  output logic          fifo_off
);
  logic pop_w;

  always_ff @(posedge clk) begin
    if (rst) fifo_off <= 1'b1;
    else     fifo_off <= ~fifo_on;
  end

  psq_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) store_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (~fifo_on),
    .wr    (host_wr),
    .wdata (host_data),
    .rd    (pop_w),
    .rdata (prn_data),
    .count (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  psq_seq seq_i (
    .clk         (clk),
    .rst         (rst),
    .en          (fifo_on),
    .empty       (fifo_empty),
    .tsel        (tsel),
    .hs_busy_sel (hs_busy_sel),
    .busy        (prn_busy),
    .ack_n       (prn_ack_n),
    .pop         (pop_w),
    .strobe_n    (prn_strobe_n)
  );

endmodule

// File: rtl/psq_chk.sv
module psq_chk #(
  parameter int DEPTH = 83,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          wr,
  input logic          pop,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          empty,
  input logic          strobe_n
);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    en && full && wr && !pop |=> $stable(count));

  // R5
  wr_pop_chk: assert property (@(posedge clk) disable iff (rst)
    en && wr && pop && !full |=> $stable(count));

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> en && !empty);

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> count == '0 && strobe_n);

endmodule

bind prn_strobe_fifo psq_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .en       (fifo_on),
  .wr       (host_wr),
  .pop      (pop_w),
  .count    (fifo_cnt),
  .full     (fifo_full),
  .empty    (fifo_empty),
  .strobe_n (prn_strobe_n)
);

// File: tb/prn_strobe_fifo_tb_top.sv
module prn_strobe_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 83;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       fifo_on = 1'b0;
  logic [2:0] tsel = 3'b100;
  logic       hs_busy_sel = 1'b0;
  logic       prn_busy = 1'b0;
  logic       prn_ack_n = 1'b1;
  logic [7:0] prn_data;
  logic       prn_strobe_n;
  logic       fifo_full, fifo_empty, fifo_off;
  logic [6:0] fifo_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  prn_strobe_fifo dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_data(host_data),
    .fifo_on(fifo_on), .tsel(tsel), .hs_busy_sel(hs_busy_sel),
    .prn_busy(prn_busy), .prn_ack_n(prn_ack_n), .prn_data(prn_data),
    .prn_strobe_n(prn_strobe_n), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .fifo_cnt(fifo_cnt), .fifo_off(fifo_off)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R1";
  bit    armed = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] mq[$];
  int  m_st = 0, m_rem = 0, m_wid = 0;
  bit  m_stb = 1, m_ackp = 1, m_dis = 1;
  int  m_pd = 0;

  function automatic int t_dly(input logic [2:0] s);
    case (s)
      3'b100: return 3;   3'b101: return 5;
      3'b110: return 5;   3'b111: return 9;
      3'b000: return 6;   3'b001: return 10;
      3'b010: return 10;  default: return 18;
    endcase
  endfunction

  function automatic int t_wid(input logic [2:0] s);
    return (s[2] ? t_dly(s) - 1 : t_dly(s) - 2);
  endfunction

  always @(posedge clk) begin
    int  sz;
    bit  fall, wr_ok;
    cyc++;
    if (rst) begin
      mq.delete(); m_st = 0; m_rem = 0; m_stb = 1; m_pd = 0; m_dis = 1;
      armed = 1;
    end else begin
      m_dis = !fifo_on;
      if (!fifo_on) begin
        mq.delete(); m_st = 0; m_stb = 1;
      end else begin
        sz    = mq.size();
        fall  = m_ackp && !prn_ack_n;
        wr_ok = host_wr && (sz < DEPTH);
        case (m_st)
          0: if (sz > 0) begin
               m_pd = int'(mq.pop_front());
               m_rem = t_dly(tsel); m_wid = t_wid(tsel); m_st = 1;
             end
          1: begin m_rem--; if (m_rem == 0) begin m_stb = 0; m_rem = m_wid; m_st = 2; end end
          2: begin m_rem--; if (m_rem == 0) begin m_stb = 1; m_st = 3; end end
          default: if (hs_busy_sel ? !prn_busy : fall) m_st = 0;
        endcase
        if (wr_ok) mq.push_back(host_data);
      end
    end
    m_ackp = rst ? 1'b1 : prn_ack_n;
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (armed) begin
      chk({phase, " R7 strobe"}, int'(prn_strobe_n), int'(m_stb));
      chk({phase, " R6 data"},   int'(prn_data), m_pd);
      chk({phase, " R3 count"},  int'(fifo_cnt), mq.size());
      chk({phase, " R3 empty"},  int'(fifo_empty), int'(mq.size() == 0));
      chk({phase, " R4 full"},   int'(fifo_full), int'(mq.size() == DEPTH));
      chk({phase, " R2 off"},    int'(fifo_off), int'(m_dis));
    end
  end

  // ---------------- printer responder ----------------
  // mode 0: hold ack high and busy low (stall in ack mode)
  // mode 1: ack pulse after strobe release; 2: busy during and after strobe;
  // mode 3: ack low while strobe low, then a fresh pulse after release
  int resp_mode = 0, rc = -1;
  bit prev_s = 1;

  always @(negedge clk) begin
    bit rise, sfall;
    rise  = !prev_s && prn_strobe_n;
    sfall = prev_s && !prn_strobe_n;
    if (resp_mode == 0) begin
      prn_ack_n = 1'b1; prn_busy = 1'b0;
    end else begin
      if (sfall && resp_mode == 2) prn_busy = 1'b1;
      if (sfall && resp_mode == 3) prn_ack_n = 1'b0;
      if (rise) begin
        rc = 3;
        if (resp_mode == 3) prn_ack_n = 1'b1;
      end else if (rc > 0) rc--;
      if (rc == 0) begin
        if (resp_mode == 2) prn_busy = 1'b0; else prn_ack_n = 1'b0;
        rc = -2;
      end else if (rc == -2) begin
        prn_ack_n = 1'b1; rc = -1;
      end
    end
    prev_s = prn_strobe_n;
  end

  // ---------------- stimulus ----------------
  task automatic host_put(input logic [7:0] d);
    host_wr = 1'b1; host_data = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic drain();
    int g = 0;
    while ((mq.size() != 0 || m_st != 0) && g < 20000) begin
      @(negedge clk); g++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    while (cyc < 150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 strobe", int'(prn_strobe_n), 1);
    chk("R1 count",  int'(fifo_cnt), 0);
    chk("R1 empty",  int'(fifo_empty), 1);
    chk("R1 full",   int'(fifo_full), 0);
    chk("R1 off",    int'(fifo_off), 1);
    chk("R1 data",   int'(prn_data), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 writes while disabled
    phase = "R2";
    for (int i = 0; i < 3; i++) host_put(8'hA0 + 8'(i));
    chk("R2 count after writes while off", int'(fifo_cnt), 0);
    chk("R2 strobe idle while off", int'(prn_strobe_n), 1);
    fifo_on = 1'b1;
    @(negedge clk);
    chk("R2 off flag cleared", int'(fifo_off), 0);

    // R6 ordering with ack handshake
    phase = "R6"; resp_mode = 1; tsel = 3'b100;
    for (int i = 0; i < 5; i++) host_put(8'h10 + 8'(i));
    drain();

    // R7 every timing code
    phase = "R7";
    for (int s = 0; s < 8; s++) begin
      tsel = 3'(s);
      host_put(8'h30 + 8'(s));
      drain();
    end

    // R9 busy handshake
    phase = "R9"; resp_mode = 2; hs_busy_sel = 1'b1; tsel = 3'b101;
    for (int i = 0; i < 4; i++) host_put(8'h50 + 8'(i));
    drain();

    // R8 early acknowledge ignored
    phase = "R8"; resp_mode = 3; hs_busy_sel = 1'b0; tsel = 3'b000;
    for (int i = 0; i < 4; i++) host_put(8'h60 + 8'(i));
    drain();

    // R4 fill while stalled
    phase = "R4"; resp_mode = 0; tsel = 3'b100;
    for (int i = 0; i < 90; i++) host_put(8'(i));
    chk("R4 count at full", int'(fifo_cnt), DEPTH);
    chk("R4 full flag", int'(fifo_full), 1);
    host_put(8'hEE);
    chk("R4 count after dropped write", int'(fifo_cnt), DEPTH);

    // R5 / R10 release and keep writing while draining
    phase = "R5 R10";
    @(posedge clk); #1;
    resp_mode = 1; rc = 2;
    for (int i = 0; i < 300; i++) host_put(8'h80 + 8'(i % 64));
    drain();

    // R11 flush mid-transfer
    phase = "R11"; tsel = 3'b011;
    for (int i = 0; i < 6; i++) host_put(8'hC0 + 8'(i));
    repeat (12) @(negedge clk);
    fifo_on = 1'b0;
    @(negedge clk);
    chk("R11 count after flush", int'(fifo_cnt), 0);
    chk("R11 strobe after flush", int'(prn_strobe_n), 1);
    chk("R11 empty after flush", int'(fifo_empty), 1);
    fifo_on = 1'b1;
    tsel = 3'b100;
    host_put(8'h5A);
    drain();
    chk("R11 only new byte sent", int'(prn_data), 8'h5A);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule